// File: doc/BRIEF.md
# Audio Frame Step Sequencer

This block produces the slow timing strobes that drive the envelope, linear-counter, length-counter and sweep units of a retro sound generator. A tick divider counts CPU-cycle enables and yields a step roughly 240 times a second. A step counter walks through either a four-step or a five-step cycle. Each step may emit a quarter-frame strobe, a half-frame strobe and, in four-step mode only, an interrupt request.

Software writes a two-bit control word: one bit picks five-step mode and the other blocks the interrupt. A write restarts the cycle after a delay of two or three CPU cycles. The delay depends on the parity of the CPU cycle in which the write lands. The write also fires strobes at once. The sequencer runs on its own and is not tied to any video timing. The interrupt stays high until the clear input is pulsed or an inhibiting write arrives.

Top module: `frame_step_seq`

## Requirements
- R1: After reset, all outputs are low, the block is in four-step mode with the interrupt not inhibited, and the first step (step 1) occurs on the TICK_CYCLES-th cpu_ce cycle after reset release.
- R2: Steps follow one another every TICK_CYCLES cycles in which cpu_ce is high. Cycles with cpu_ce low advance nothing and produce no strobe.
- R3: In four-step mode (wr_mode5=0), qtr_stb pulses on steps 1 to 4 and half_stb pulses on steps 2 and 4. Each strobe is high for the one clock that follows the step's cpu_ce cycle.
- R4: In five-step mode (wr_mode5=1), qtr_stb pulses on steps 1 to 4 and half_stb pulses on steps 1 and 3. Step 5 emits nothing.
- R5: irq goes high together with the step-4 strobes in four-step mode when the interrupt is not inhibited. It never goes high in five-step mode, and it stays high until cleared.
- R6: A one-clock irq_clr pulse drops irq. A write with wr_irq_inhibit=1 drops irq on that write and prevents later assertion until a write clears the inhibit.
- R7: A write is accepted when wr_en and cpu_ce are both high. It loads the mode from wr_mode5 and the inhibit from wr_irq_inhibit. In the next clock it pulses qtr_stb, and it also pulses half_stb when wr_mode5=1.
- R8: A cpu_ce parity bit starts at even after reset and flips on every cpu_ce cycle. A write in an even cycle restarts the cycle 2 cpu_ce cycles later, and a write in an odd cycle restarts it 3 cpu_ce cycles later. No step occurs in between. Step 1 follows the restart after TICK_CYCLES further cpu_ce cycles.
- R9: wr_en asserted while cpu_ce is low is ignored: it changes neither the mode, the inhibit nor the strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| cpu_ce | input | 1 | One-clock enable marking each CPU cycle |
| wr_en | input | 1 | Control write strobe |
| wr_mode5 | input | 1 | Write data: 1 selects the five-step cycle |
| wr_irq_inhibit | input | 1 | Write data: 1 blocks and clears the interrupt |
| irq_clr | input | 1 | Interrupt acknowledge pulse |
| qtr_stb | output | 1 | Envelope / linear-counter strobe |
| half_stb | output | 1 | Length-counter / sweep strobe |
| irq | output | 1 | Sticky interrupt request level |

## Verification
On every cycle, the assertions check the following. A half-frame strobe never appears without a quarter-frame strobe. No strobe follows a cycle without cpu_ce. An accepted write yields the immediate strobes that match its mode bit. irq stays sticky and rises only together with the full step-4 strobe pair, and an inhibiting write clears it. Only the bench's scenarios can show the rest, by checking every clock against an independent timeline: the exact step positions of both patterns, the 2-versus-3 cycle restart that depends on parity, a restart in the middle of a five-step cycle, and the fact that a stall or a write without cpu_ce leaves the phase untouched.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

  localparam int unsigned STEP_W = 3;

  typedef struct packed {
    logic qtr;
    logic half;
    logic irq;
  } step_evt_t;

  // Strobe pattern for a zero-based step index in either cycle length.
  function automatic step_evt_t step_pattern(input logic mode5, input logic [STEP_W-1:0] idx);
    step_evt_t e;
    e = '0;
    if (mode5) begin
      e.qtr  = (idx <= 3'd3);
      e.half = (idx == 3'd0) || (idx == 3'd2);
      e.irq  = 1'b0;
    end else begin
      e.qtr  = 1'b1;
      e.half = (idx == 3'd1) || (idx == 3'd3);
      e.irq  = (idx == 3'd3);
    end
    return e;
  endfunction

endpackage

// File: rtl/fseq_ctrl.sv
module fseq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_ce,
  input  logic wr_en,
  input  logic wr_mode5,
  input  logic wr_irq_inhibit,
  output logic mode5,
  output logic inhibit,
  output logic wr_acc,
  output logic hold,
  output logic restart
);

  logic       parity_q, parity_d;
  logic [1:0] pend_q, pend_d;
  logic       mode_q, mode_d;
  logic       inh_q, inh_d;

  assign wr_acc  = cpu_ce & wr_en;
  assign hold    = wr_acc | (pend_q != 2'd0);
  assign restart = cpu_ce & ~wr_acc & (pend_q == 2'd1);
  assign mode5   = mode_q;
  assign inhibit = inh_q;

  always_comb begin
    parity_d = parity_q;
    pend_d   = pend_q;
    mode_d   = mode_q;
    inh_d    = inh_q;
    if (cpu_ce) begin
      parity_d = ~parity_q;
    end
    if (wr_acc) begin
      pend_d = parity_q ? 2'd3 : 2'd2;
      mode_d = wr_mode5;
      inh_d  = wr_irq_inhibit;
    end else if (cpu_ce && (pend_q != 2'd0)) begin
      pend_d = pend_q - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      parity_q <= 1'b0;
      pend_q   <= 2'd0;
      mode_q   <= 1'b0;
      inh_q    <= 1'b0;
    end else begin
      parity_q <= parity_d;
      pend_q   <= pend_d;
      mode_q   <= mode_d;
      inh_q    <= inh_d;
    end
  end

endmodule

// File: rtl/fseq_divider.sv
module fseq_divider #(
  parameter int unsigned TICK_CYCLES = 7457
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic tick
);

  localparam int unsigned CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = en & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = '0;
    end else if (en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/fseq_stepper.sv
module fseq_stepper
  import fseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode5,
  input  logic      tick,
  input  logic      restart,
  output step_evt_t evt
);

  logic [STEP_W-1:0] step_q, step_d;
  logic              last;
  step_evt_t         pat;

  assign last = mode5 ? (step_q == 3'd4) : (step_q == 3'd3);
  assign pat  = step_pattern(mode5, step_q);

  always_comb begin
    evt = '0;
    if (tick) begin
      evt = pat;
    end
  end

  always_comb begin
    step_d = step_q;
    if (restart) begin
      step_d = '0;
    end else if (tick) begin
      step_d = last ? '0 : step_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
    end else begin
      step_q <= step_d;
    end
  end

endmodule

// File: rtl/frame_step_seq.sv
module frame_step_seq
  import fseq_pkg::*;
#(
  parameter int unsigned TICK_CYCLES = 7457
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cpu_ce,
  input  logic wr_en,
  input  logic wr_mode5,
  input  logic wr_irq_inhibit,
  input  logic irq_clr,
  output logic qtr_stb,
  output logic half_stb,
  output logic irq
);

  logic      mode5, inhibit, wr_acc, hold, restart, tick;
  step_evt_t evt;
  logic      qtr_q, qtr_d, half_q, half_d, irq_q, irq_d;

  fseq_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .cpu_ce         (cpu_ce),
    .wr_en          (wr_en),
    .wr_mode5       (wr_mode5),
    .wr_irq_inhibit (wr_irq_inhibit),
    .mode5          (mode5),
    .inhibit        (inhibit),
    .wr_acc         (wr_acc),
    .hold           (hold),
    .restart        (restart)
  );

  fseq_divider #(.TICK_CYCLES(TICK_CYCLES)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cpu_ce & ~hold),
    .clr   (restart),
    .tick  (tick)
  );

  fseq_stepper u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode5   (mode5),
    .tick    (tick),
    .restart (restart),
    .evt     (evt)
  );

  always_comb begin
    qtr_d  = evt.qtr | wr_acc;
    half_d = evt.half | (wr_acc & wr_mode5);
    irq_d  = irq_q;
    if (evt.irq && !inhibit) begin
      irq_d = 1'b1;
    end else if (irq_clr || (wr_acc && wr_irq_inhibit)) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qtr_q  <= 1'b0;
      half_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      qtr_q  <= qtr_d;
      half_q <= half_d;
      irq_q  <= irq_d;
    end
  end

  assign qtr_stb  = qtr_q;
  assign half_stb = half_q;
  assign irq      = irq_q;

endmodule

// File: rtl/fseq_checker.sv
module fseq_checker (
  input logic clk,
  input logic rst_n,
  input logic cpu_ce,
  input logic wr_en,
  input logic wr_mode5,
  input logic wr_irq_inhibit,
  input logic irq_clr,
  input logic qtr_stb,
  input logic half_stb,
  input logic irq
);

  AST_HALF_WITH_QTR: assert property (@(posedge clk) disable iff (!rst_n)
    half_stb |-> qtr_stb);  // R3

  AST_IDLE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ce |=> (!qtr_stb && !half_stb));  // R2

  AST_WRITE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cpu_ce) |=> (qtr_stb && (half_stb == $past(wr_mode5))));  // R7

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr && !(wr_en && cpu_ce && wr_irq_inhibit)) |=> irq);  // R5

  AST_INHIBIT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cpu_ce && wr_irq_inhibit) |=> !irq);  // R6

  AST_IRQ_ON_STEP4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (qtr_stb && half_stb));  // R5

endmodule

bind frame_step_seq fseq_checker u_fseq_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .cpu_ce         (cpu_ce),
  .wr_en          (wr_en),
  .wr_mode5       (wr_mode5),
  .wr_irq_inhibit (wr_irq_inhibit),
  .irq_clr        (irq_clr),
  .qtr_stb        (qtr_stb),
  .half_stb       (half_stb),
  .irq            (irq)
);

// File: tb/tb_frame_step_seq.sv
`timescale 1ns/1ps
module tb_frame_step_seq;

  localparam int TICK = 4;

  logic clk, rst_n, cpu_ce, wr_en, wr_mode5, wr_irq_inhibit, irq_clr;
  logic qtr_stb, half_stb, irq;

  int checks = 0;
  int errors = 0;
  int ncpu   = 0;
  int cyc    = 0;
  logic exp_irq = 1'b0;

  frame_step_seq #(.TICK_CYCLES(TICK)) dut (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en),
    .wr_mode5(wr_mode5), .wr_irq_inhibit(wr_irq_inhibit), .irq_clr(irq_clr),
    .qtr_stb(qtr_stb), .half_stb(half_stb), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // CPU-cycle count since reset release: its parity predicts the restart delay.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && cpu_ce) ncpu <= ncpu + 1;
  end

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check_outs(input string req, input logic q, input logic h, input logic i);
    check(req, "qtr_stb", qtr_stb, q);
    check(req, "half_stb", half_stb, h);
    check(req, "irq", irq, i);
  endtask

  // Checks offsets 1..n after the current negedge; steps at first, first+TICK, ...
  task automatic check_run(input int n, input int first, input logic m5, input logic inh);
    for (int j = 1; j <= n; j++) begin
      logic q, h, ir;
      int k, s;
      q = 1'b0; h = 1'b0; ir = 1'b0;
      @(negedge clk);
      if (j >= first && ((j - first) % TICK) == 0) begin
        k = (j - first) / TICK;
        s = m5 ? (k % 5) : (k % 4);
        if (m5) begin
          q = (s <= 3); h = (s == 0) || (s == 2);
        end else begin
          q = 1'b1; h = (s == 1) || (s == 3); ir = (s == 3);
        end
        if (ir && !inh) exp_irq = 1'b1;
      end
      check(m5 ? "R4" : "R3", "qtr_stb", qtr_stb, q);
      check(m5 ? "R4" : "R3", "half_stb", half_stb, h);
      check("R5", "irq", irq, exp_irq);
    end
  endtask

  // Write landing on an even (odd=0) or odd CPU cycle; returns the restart delay.
  task automatic do_write(input logic m5, input logic inh, input logic odd, output int dly);
    if (((ncpu % 2) == 1) != odd) @(negedge clk);
    wr_en = 1'b1; wr_mode5 = m5; wr_irq_inhibit = inh;
    @(negedge clk);
    wr_en = 1'b0; wr_mode5 = 1'b0; wr_irq_inhibit = 1'b0;
    if (inh) exp_irq = 1'b0;
    check("R7", "write qtr_stb", qtr_stb, 1'b1);
    check("R7", "write half_stb", half_stb, m5);
    check("R6", "write irq", irq, exp_irq);
    dly = odd ? 3 : 2;
  endtask

  task automatic t_reset_freerun();
    rst_n = 1'b0; cpu_ce = 1'b1; wr_en = 1'b0; wr_mode5 = 1'b0;
    wr_irq_inhibit = 1'b0; irq_clr = 1'b0;
    repeat (3) @(negedge clk);
    check_outs("R1", 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    // R1: first step after TICK cycles, four-step pattern, irq on step 4, sticky (R5)
    check_run(34, TICK, 1'b0, 1'b0);
  endtask

  task automatic t_irq_clear();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    exp_irq = 1'b0;
    check("R6", "irq after irq_clr", irq, 1'b0);
  endtask

  task automatic t_five_step();
    int d;
    do_write(1'b1, 1'b0, 1'b0, d);
    check("R8", "even delay", (d == 2), 1'b1);
    check_run(d + 40 + 2, d + TICK, 1'b1, 1'b0);   // R4, R8: no irq in five-step
  endtask

  task automatic t_four_step_odd();
    int d;
    do_write(1'b0, 1'b0, 1'b1, d);                  // R8: odd cycle, restart after 3
    check_run(d + 16 + 1, d + TICK, 1'b0, 1'b0);
    check("R5", "irq raised at step 4", irq, 1'b1);
  endtask

  task automatic t_inhibit();
    int d;
    do_write(1'b0, 1'b1, 1'b0, d);                  // R6: clears pending irq
    check_run(d + 32, d + TICK, 1'b0, 1'b1);
  endtask

  task automatic t_stall_ignore();
    int d;
    do_write(1'b0, 1'b0, 1'b0, d);
    cpu_ce = 1'b0;
    wr_en = 1'b1; wr_mode5 = 1'b1; wr_irq_inhibit = 1'b1;  // R9: must be ignored
    @(negedge clk);
    wr_en = 1'b0; wr_mode5 = 1'b0; wr_irq_inhibit = 1'b0;
    check_outs("R9", 1'b0, 1'b0, exp_irq);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check_outs("R2", 1'b0, 1'b0, exp_irq);
    end
    cpu_ce = 1'b1;
    // phase unchanged by the stall (R2); four-step and non-inhibited still in force (R9)
    check_run(d + 16 + 1, d + TICK, 1'b0, 1'b0);
    check("R9", "irq not inhibited", irq, 1'b1);
  endtask

  initial begin
    t_reset_freerun();
    t_irq_clear();
    t_five_step();
    t_four_step_odd();
    t_inhibit();
    t_stall_ignore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule